// File: doc/BRIEF.md
# Word Boundary Recovery and Sync Tracker

This block takes 10-bit words straight from a deserializer and finds the word boundary in them. The received bit stream can sit at any bit offset relative to the deserializer's word clock. Each cycle the block joins the previous word and the current word into a 20-bit window. It looks for a comma pattern, set by a parameter, at all ten offsets. When it finds one it locks that offset and sends the realigned word downstream.

The block then tracks link synchronization with hysteresis. Sync is declared only after a parameterized number of patterns arrive on the locked boundary. Once in sync, an external decoder reports each bad code or disparity error through a per-word error flag, and each flag raises an error count. A parameterized run of clean words lowers that count by one. If the count drains back to zero, the block returns to full lock without a new search. If the count reaches a separate limit, the block drops sync, clears its counters and searches every offset again. A realign request forces that same restart, so the block locks to the next pattern that arrives.

Top module: `wa_sync_top`

## Requirements
- R1: While `rst` is high, and on the first sample after it falls, `sync_state` is 0, `sync_status` is 0, `pat_det` is 0 and `boundary` is 0.
- R2: State codes are 0 = searching, 1 = acquiring, 2 = locked, 3 = recovering. While searching, the first pattern found at any offset 0..9 sets `boundary` to that offset and moves the state to 1, or to 2 if `SYNC_PATS` is at most 1. Offset k is window bits [19-k:10-k], where window = {previous word, current word} and bit 9 of each word is the earliest received.
- R3: In state 1, when the `SYNC_PATS`-th pattern (counting the first) is seen on the locked offset, the state becomes 2 and `sync_status` goes high. Neither happens earlier.
- R4: Outside the search state, `pat_det` is high for exactly those words whose aligned value matches the pattern at the locked offset. While searching, it is high for a word in which a pattern is found.
- R5: In state 2, a word flagged by `code_err` moves the state to 3 with an error count of 1. `sync_status` stays high in states 2 and 3.
- R6: In state 3, every `GOOD_RUN` consecutive unflagged words lower the error count by one. When the count reaches zero, the state returns to 2.
- R7: A flagged word in state 3 restarts the run of clean words from zero.
- R8: When the error count reaches `ERR_LIMIT`, the state becomes 0, `sync_status` falls, and all counters clear.
- R9: `code_err` has no effect in state 0. In state 1 it returns the block to state 0.
- R10: A `realign_req` pulse puts the block in state 0 one cycle later. The block then locks to the next pattern that arrives.
- R11: `aligned_data` is the word at the locked offset, taken from the window one cycle earlier.
- R12: `boundary` does not change while the state stays outside 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 10 | Raw deserialized word, bit 9 earliest |
| code_err | input | 1 | Decoder error flag for the aligned word formed this cycle |
| realign_req | input | 1 | Forces a new boundary search |
| aligned_data | output | 10 | Word at the locked offset |
| pat_det | output | 1 | Pattern seen on the current boundary |
| sync_status | output | 1 | High in locked and recovering states |
| sync_state | output | 2 | Tracker state code |
| boundary | output | 4 | Locked bit offset 0..9 |

## Verification
An aligned slot j first fills the window in cycle j+1. Its `code_err` and any `realign_req` for it are driven in that same cycle. Every result for that slot (state, sync, `pat_det`, boundary and aligned word) appears after the register stage that closes cycle j+1. The bench therefore checks slot j at the falling edge of cycle j+2. The slot streams are built with a random bit slip, so the expected boundary is simply that slip. The counter thresholds are checked on the slot just before each transition and on the slot that completes it.

// File: rtl/wa_pkg.sv
package wa_pkg;

    typedef enum logic [1:0] {
        ST_LOS   = 2'd0,
        ST_ACQ   = 2'd1,
        ST_SYNC  = 2'd2,
        ST_RECOV = 2'd3
    } wa_state_e;

    // a threshold of zero behaves like one
    function automatic int unsigned floor_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int unsigned width_for(input int unsigned maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

endpackage

// File: rtl/wa_window_match.sv
module wa_window_match #(
    parameter int unsigned W       = 10,
    parameter int unsigned PAT_LEN = 10,
    parameter logic [W-1:0] PATTERN = 10'b0011111010
) (
    input  logic [W-1:0] prev_word,
    input  logic [W-1:0] cur_word,
    output logic [W-1:0] hits,
    output logic [W-1:0] words [W]
);
    localparam logic [PAT_LEN-1:0] KEY = PATTERN[W-1 -: PAT_LEN];

    logic [2*W-1:0] win;
    assign win = {prev_word, cur_word};

    for (genvar k = 0; k < W; k++) begin : g_ofs
        assign words[k] = win[2*W-1-k -: W];
        assign hits[k]  = (words[k][W-1 -: PAT_LEN] == KEY);
    end
endmodule

// File: rtl/wa_first_hit.sv
module wa_first_hit #(
    parameter int unsigned N  = 10,
    parameter int unsigned OW = 4
) (
    input  logic [N-1:0]  hits,
    output logic          any,
    output logic [OW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = OW'(i);
        end
    end
    assign any = |hits;
endmodule

// File: rtl/wa_sync_fsm.sv
module wa_sync_fsm
    import wa_pkg::*;
#(
    parameter int unsigned W         = 10,
    parameter int unsigned OFS_W     = 4,
    parameter int unsigned SYNC_PATS = 3,
    parameter int unsigned ERR_LIMIT = 3,
    parameter int unsigned GOOD_RUN  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             realign,
    input  logic             code_err,
    input  logic [W-1:0]     hits,
    input  logic             any_hit,
    input  logic [OFS_W-1:0] first_idx,
    output wa_state_e        state,
    output logic [OFS_W-1:0] ofs,
    output logic [OFS_W-1:0] sel_ofs,
    output logic             det
);
    localparam int unsigned SYNC_EFF = floor_one(SYNC_PATS);
    localparam int unsigned ERR_EFF  = floor_one(ERR_LIMIT);
    localparam int unsigned GOOD_EFF = floor_one(GOOD_RUN);
    localparam int unsigned PAT_W    = width_for(SYNC_EFF);
    localparam int unsigned ERR_W    = width_for(ERR_EFF);
    localparam int unsigned GOOD_W   = width_for(GOOD_EFF);

    typedef struct packed {
        wa_state_e         st;
        logic [OFS_W-1:0]  ofs;
        logic [PAT_W-1:0]  pat;
        logic [ERR_W-1:0]  err;
        logic [GOOD_W-1:0] good;
    } ctx_t;

    ctx_t cur, nxt;
    logic det_d, locked_hit;

    assign locked_hit = hits[cur.ofs];
    assign sel_ofs    = (cur.st == ST_LOS) ? first_idx : cur.ofs;

    always_comb begin
        nxt   = cur;
        det_d = (cur.st == ST_LOS) ? any_hit : locked_hit;
        if (realign) begin
            nxt = '0;
        end else begin
            unique case (cur.st)
                ST_LOS: begin
                    if (any_hit) begin
                        nxt.ofs = first_idx;
                        nxt.pat = PAT_W'(1);
                        nxt.st  = (SYNC_EFF == 1) ? ST_SYNC : ST_ACQ;
                    end
                end
                ST_ACQ: begin
                    if (code_err) begin
                        nxt = '0;
                    end else if (locked_hit) begin
                        if (cur.pat == PAT_W'(SYNC_EFF - 1)) begin
                            nxt.st  = ST_SYNC;
                            nxt.pat = '0;
                        end else begin
                            nxt.pat = cur.pat + PAT_W'(1);
                        end
                    end
                end
                ST_SYNC: begin
                    if (code_err) begin
                        if (ERR_EFF == 1) begin
                            nxt = '0;
                        end else begin
                            nxt.st   = ST_RECOV;
                            nxt.err  = ERR_W'(1);
                            nxt.good = '0;
                        end
                    end
                end
                ST_RECOV: begin
                    if (code_err) begin
                        nxt.good = '0;
                        if (cur.err == ERR_W'(ERR_EFF - 1)) nxt = '0;
                        else                                 nxt.err = cur.err + ERR_W'(1);
                    end else if (cur.good == GOOD_W'(GOOD_EFF - 1)) begin
                        nxt.good = '0;
                        nxt.err  = cur.err - ERR_W'(1);
                        if (cur.err == ERR_W'(1)) nxt.st = ST_SYNC;
                    end else begin
                        nxt.good = cur.good + GOOD_W'(1);
                    end
                end
                default: nxt = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
            det <= 1'b0;
        end else begin
            cur <= nxt;
            det <= det_d;
        end
    end

    assign state = cur.st;
    assign ofs   = cur.ofs;
endmodule

// File: rtl/wa_sync_top.sv
module wa_sync_top
    import wa_pkg::*;
#(
    parameter int unsigned  W         = 10,
    parameter int unsigned  PAT_LEN   = 10,
    parameter logic [W-1:0] PATTERN   = 10'b0011111010,
    parameter int unsigned  SYNC_PATS = 3,
    parameter int unsigned  ERR_LIMIT = 3,
    parameter int unsigned  GOOD_RUN  = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [9:0]   rx_data,
    input  logic         code_err,
    input  logic         realign_req,
    output logic [9:0]   aligned_data,
    output logic         pat_det,
    output logic         sync_status,
    output logic [1:0]   sync_state,
    output logic [3:0]   boundary
);
    localparam int unsigned OFS_W = $clog2(W);

    logic [W-1:0]     prev_q;
    logic [W-1:0]     hits;
    logic [W-1:0]     words [W];
    logic             any_hit;
    logic [OFS_W-1:0] first_idx, ofs, sel_ofs;
    wa_state_e        st;

    wa_window_match #(.W(W), .PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) u_match (
        .prev_word(prev_q), .cur_word(rx_data), .hits(hits), .words(words)
    );

    wa_first_hit #(.N(W), .OW(OFS_W)) u_pick (
        .hits(hits), .any(any_hit), .idx(first_idx)
    );

    wa_sync_fsm #(
        .W(W), .OFS_W(OFS_W), .SYNC_PATS(SYNC_PATS),
        .ERR_LIMIT(ERR_LIMIT), .GOOD_RUN(GOOD_RUN)
    ) u_fsm (
        .clk(clk), .rst(rst), .realign(realign_req), .code_err(code_err),
        .hits(hits), .any_hit(any_hit), .first_idx(first_idx),
        .state(st), .ofs(ofs), .sel_ofs(sel_ofs), .det(pat_det)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q       <= '0;
            aligned_data <= '0;
        end else begin
            prev_q       <= rx_data;
            aligned_data <= words[sel_ofs];
        end
    end

    assign sync_state  = st;
    assign sync_status = (st == ST_SYNC) || (st == ST_RECOV);
    assign boundary    = 4'(ofs);
endmodule

// File: rtl/wa_sync_chk.sv
module wa_sync_chk
    import wa_pkg::*;
#(
    parameter int unsigned ERR_LIMIT = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       code_err,
    input logic       realign_req,
    input logic       pat_det,
    input logic       sync_status,
    input logic [1:0] sync_state,
    input logic [3:0] boundary
);
    localparam int unsigned ERR_EFF = floor_one(ERR_LIMIT);

    a_r12_boundary_held: assert property (@(posedge clk) disable iff (rst)
        (sync_state != 2'd0) && ($past(sync_state) != 2'd0) |-> $stable(boundary));

    a_r10_realign_restart: assert property (@(posedge clk) disable iff (rst)
        realign_req |=> (sync_state == 2'd0));

    a_r3_sync_on_pattern: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_status) |-> pat_det);

    a_r8_loss_to_search: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_status) |-> (sync_state == 2'd0));

    a_r5_error_enters_recovery: assert property (@(posedge clk) disable iff (rst)
        (ERR_EFF > 1) && (sync_state == 2'd2) && code_err && !realign_req
        |=> (sync_state == 2'd3) && sync_status);

    a_r2_offset_range: assert property (@(posedge clk) disable iff (rst)
        boundary <= 4'd9);
endmodule

bind wa_sync_top wa_sync_chk #(.ERR_LIMIT(ERR_LIMIT)) u_chk (
    .clk(clk), .rst(rst), .code_err(code_err), .realign_req(realign_req),
    .pat_det(pat_det), .sync_status(sync_status), .sync_state(sync_state),
    .boundary(boundary)
);

// File: tb/sim_wa_sync_top.sv
module sim_wa_sync_top;
    localparam int NSLOT = 80;
    localparam int NBITS = (NSLOT + 3) * 10;
    localparam logic [9:0] COMMA = 10'b0011111010;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] rx_data = '0;
    logic       code_err = 1'b0;
    logic       realign_req = 1'b0;
    logic [9:0] aligned_data;
    logic       pat_det, sync_status;
    logic [1:0] sync_state;
    logic [3:0] boundary;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int slip;
    logic       bits [NBITS];
    logic [9:0] slot_word [NSLOT];

    wa_sync_top u0 (
        .clk(clk), .rst(rst), .rx_data(rx_data), .code_err(code_err),
        .realign_req(realign_req), .aligned_data(aligned_data), .pat_det(pat_det),
        .sync_status(sync_status), .sync_state(sync_state), .boundary(boundary)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            errors = errors + 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit is_comma(input int j);
        return j == 5 || j == 8 || j == 10 || j == 15 || j == 56 ||
               j == 60 || j == 62 || j == 64 || j == 68;
    endfunction

    function automatic bit is_err(input int j);
        return j == 20 || j == 21 || j == 33 || j == 37 || j == 50 ||
               j == 51 || j == 52 || j == 53 || j == 58;
    endfunction

    // data words without three equal bits in a row cannot mimic the comma
    function automatic logic [9:0] safe_word();
        logic [9:0] w;
        bit bad;
        do begin
            w = 10'($urandom);
            bad = 0;
            for (int i = 0; i < 8; i++)
                if (w[i] == w[i+1] && w[i+1] == w[i+2]) bad = 1;
        end while (bad);
        return w;
    endfunction

    task automatic build_stream(input int s);
        for (int i = 0; i < NBITS; i++) bits[i] = 1'b0;
        for (int j = 0; j < NSLOT; j++) begin
            slot_word[j] = is_comma(j) ? COMMA : safe_word();
            for (int b = 0; b < 10; b++) bits[s + j*10 + b] = slot_word[j][9-b];
        end
    endtask

    task automatic check_slot(input int j);
        case (j)
            5:  begin chk("R2 state", sync_state, 1); chk("R2 boundary", boundary, slip);
                      chk("R2 det", pat_det, 1); chk("R3 early sync", sync_status, 0); end
            6:  chk("R4 no det", pat_det, 0);
            9:  begin chk("R3 not yet", sync_status, 0); chk("R3 state", sync_state, 1); end
            10: begin chk("R3 locked", sync_state, 2); chk("R3 sync", sync_status, 1); end
            12: chk("R11 aligned", aligned_data, slot_word[12]);
            14: chk("R4 det low", pat_det, 0);
            15: chk("R4 det locked", pat_det, 1);
            20: begin chk("R5 recov", sync_state, 3); chk("R5 sync held", sync_status, 1); end
            25: chk("R6 partial", sync_state, 3);
            28: chk("R6 not drained", sync_state, 3);
            29: chk("R6 drained", sync_state, 2);
            44: chk("R7 run restarted", sync_state, 3);
            45: chk("R7 drained", sync_state, 2);
            51: begin chk("R8 before limit", sync_status, 1); chk("R8 state", sync_state, 3); end
            52: begin chk("R8 lost", sync_state, 0); chk("R8 sync low", sync_status, 0); end
            53: chk("R9 ignored in search", sync_state, 0);
            56: begin chk("R2 relock", sync_state, 1); chk("R2 boundary", boundary, slip); end
            57: chk("R12 held", boundary, slip);
            58: chk("R9 acquire error", sync_state, 0);
            64: chk("R3 relocked", sync_state, 2);
            66: begin chk("R10 search", sync_state, 0); chk("R10 sync low", sync_status, 0); end
            68: begin chk("R10 lock next", sync_state, 1); chk("R10 det", pat_det, 1);
                      chk("R10 boundary", boundary, slip); end
            default: ;
        endcase
    endtask

    task automatic run(input int s);
        slip = s;
        build_stream(s);
        rst = 1'b1; rx_data = '0; code_err = 1'b0; realign_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 state", sync_state, 0); chk("R1 sync", sync_status, 0);
        chk("R1 det", pat_det, 0);      chk("R1 boundary", boundary, 0);
        for (int c = 0; c < NSLOT + 2; c++) begin
            @(negedge clk);
            if (c >= 2) check_slot(c - 2);
            for (int b = 0; b < 10; b++) rx_data[9-b] = bits[c*10 + b];
            code_err    = (c >= 1) && is_err(c - 1);
            realign_req = (c - 1 == 66);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        run(int'($urandom % 10));
        run(0);
        run(9);
        run(int'($urandom % 10));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule